// File: doc/BRIEF.md
# FFT Bin Log-Magnitude Approximator

This block takes one complex FFT bin and returns an approximate base-2 logarithm of its power. Both parts arrive as signed fixed-point words. The block first forms the power as re² + im². That sum is never negative, so it carries no sign information.

The power is normalised by finding its leading one. The index of that bit is the integer part of the log. The bits below the leading one form the fraction of a mantissa in [1,2). They are used directly as the fractional part of the log. The result is an unsigned fixed-point word with the exponent above the fraction, and it can drive a DAC for a dB-scaled spectrum display. A dB reading needs only a constant gain of about 3.01 per log2 unit, applied downstream.

The raw-mantissa fraction has an error of up to roughly 0.085 log2 units near mantissa 1.5, and no error at 1.0. When the refine input is set with a sample, a refinement engine squares the mantissa once per clock. Each squaring yields one exact fraction bit: the bit is 1 when the square reaches 2, and the mantissa is then halved. While it is refining, the block holds its input ready low.

Top module: `fft_logmag`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: For a non-zero power P = re² + im², bits log_o[12:8] hold the index of the most significant set bit of P (the exponent, 0 to 31).
- R3: Without refinement, log_o[7:0] holds the 8 bits of P that sit directly below its leading one, most significant first, with zeros shifted in below bit 0 and any lower bits truncated.
- R4: A sample accepted without refinement (in_valid_i and in_ready_o high at a rising edge) gives out_valid_o high for one cycle, exactly two rising edges after acceptance, counting the accepting edge as the first.
- R5: When both parts are zero, zero_o is 1 and log_o is 0 (the most negative code). For every non-zero input, zero_o is 0.
- R6: With refine_i high at acceptance, log_o[7:0] holds the 8 bits produced by successive squaring of the mantissa: bit = 1 if m² ≥ 2 (then m = m²/2), else bit = 0 (then m = m²), with the first bit at log_o[7]. The output appears 10 rising edges after acceptance.
- R7: in_ready_o is 0 from the edge after a refine sample is accepted until the edge that presents its result. A valid input offered while in_ready_o is 0 is ignored and produces no output.
- R8: The result depends only on the magnitudes of the two parts, and the most negative input value (-32768 in both parts) gives exponent 31 and fraction 0.
- R9: Non-refined samples accepted on consecutive cycles produce results on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can accept a sample |
| refine_i | input | 1 | Refine the fraction by mantissa squaring for this sample |
| re_i | input | 16 | Real part, signed |
| im_i | input | 16 | Imaginary part, signed |
| out_valid_o | output | 1 | Result valid, one-cycle pulse |
| log_o | output | 13 | log2 of power: exponent in [12:8], fraction in [7:0] |
| zero_o | output | 1 | Power was zero |

## Verification
The latency properties assume that refine_i is meaningful only while in_valid_i is high. They also assume that the bench never relies on a sample being taken while in_ready_o is low. The bench changes inputs only on falling edges. It withdraws any sample it offers during a refinement before in_ready_o returns high, so that the ignored input is never accepted late. The power-range property assumes two's-complement inputs of the configured width, and the bench includes the most negative value in both parts to reach the top of that range.

// File: rtl/logmag_pkg.sv
package logmag_pkg;
  parameter int unsigned LM_IN_W    = 16;
  parameter int unsigned LM_MANT_W  = 16;
  parameter int unsigned LM_FRAC_W  = 8;
  parameter int unsigned LM_REF_ITR = 8;
endpackage

// File: rtl/logmag_sqsum.sv
module logmag_sqsum #(
  parameter int unsigned IN_W  = logmag_pkg::LM_IN_W,
  localparam int unsigned MAG_W = 2 * IN_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   take_i,
  input  logic                   ref_i,
  input  logic signed [IN_W-1:0] re_i,
  input  logic signed [IN_W-1:0] im_i,
  output logic                   vld_o,
  output logic                   ref_o,
  output logic [MAG_W-1:0]       mag_o
);
  logic signed [MAG_W-1:0] re_sq, im_sq;
  logic [MAG_W-1:0]        mag_d;

  assign re_sq = re_i * re_i;
  assign im_sq = im_i * im_i;
  assign mag_d = $unsigned(re_sq) + $unsigned(im_sq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      ref_o <= 1'b0;
      mag_o <= '0;
    end else begin
      vld_o <= take_i;
      if (take_i) begin
        ref_o <= ref_i;
        mag_o <= mag_d;
      end
    end
  end

  // R8: sum of two squares never exceeds 2^(MAG_W-1)
  a_r8_power_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (mag_o <= (MAG_W'(1) << (MAG_W - 1))));
endmodule

// File: rtl/logmag_norm.sv
module logmag_norm #(
  parameter int unsigned MAG_W  = 32,
  parameter int unsigned MANT_W = logmag_pkg::LM_MANT_W,
  parameter int unsigned FRAC_W = logmag_pkg::LM_FRAC_W,
  localparam int unsigned EXP_W = $clog2(MAG_W)
) (
  input  logic [MAG_W-1:0]  mag_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0] mant_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              zero_o
);
  logic [MAG_W-1:0] aligned;

  always_comb begin
    exp_o = '0;
    for (int i = 0; i < MAG_W; i++)
      if (mag_i[i]) exp_o = EXP_W'(i);
  end

  assign zero_o  = (mag_i == '0);
  // leading one moved to the MSB, then dropped
  assign aligned = mag_i << (EXP_W'(MAG_W - 1) - exp_o);
  assign mant_o  = MANT_W'(aligned >> (MAG_W - 1 - MANT_W));
  assign frac_o  = FRAC_W'(mant_o >> (MANT_W - FRAC_W));

  always_comb begin
    if (mag_i != '0)
      a_r2_lead_one: assert ((mag_i >> exp_o) == MAG_W'(1));
  end
endmodule

// File: rtl/logmag_refine.sv
module logmag_refine #(
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned MANT_W  = logmag_pkg::LM_MANT_W,
  parameter int unsigned FRAC_W  = logmag_pkg::LM_FRAC_W,
  parameter int unsigned REF_ITR = logmag_pkg::LM_REF_ITR,
  localparam int unsigned CNT_W  = $clog2(REF_ITR + 1),
  localparam int unsigned PROD_W = 2 * MANT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              zero_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              zero_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [MANT_W-1:0] m_q, m_nxt;
  logic [FRAC_W-1:0] acc_q, acc_nxt;
  logic [MANT_W:0]   m_full;
  logic [PROD_W-1:0] prod;
  logic [FRAC_W:0]   acc_sh;
  logic              bit_n;

  assign m_full  = {1'b1, m_q};
  assign prod    = PROD_W'(m_full) * PROD_W'(m_full);
  assign bit_n   = prod[PROD_W-1];   // square reached 2
  assign m_nxt   = bit_n ? MANT_W'(prod >> (MANT_W + 1)) : MANT_W'(prod >> MANT_W);
  assign acc_sh  = {acc_q, bit_n};
  assign acc_nxt = acc_sh[FRAC_W-1:0];
  assign last_o  = busy_o && (cnt_q == CNT_W'(REF_ITR - 1));
  assign frac_o  = acc_nxt << (FRAC_W - REF_ITR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      m_q    <= '0;
      acc_q  <= '0;
      exp_o  <= '0;
      zero_o <= 1'b0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
      m_q    <= mant_i;
      acc_q  <= '0;
      exp_o  <= exp_i;
      zero_o <= zero_i;
    end else if (busy_o) begin
      m_q    <= m_nxt;
      acc_q  <= acc_nxt;
      cnt_q  <= cnt_q + CNT_W'(1);
      if (last_o) busy_o <= 1'b0;
    end
  end

  // R6: iteration count stays inside the configured window
  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < CNT_W'(REF_ITR)));
  // R7: no new load while iterating
  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/fft_logmag.sv
module fft_logmag #(
  parameter int unsigned IN_W    = logmag_pkg::LM_IN_W,
  parameter int unsigned MANT_W  = logmag_pkg::LM_MANT_W,
  parameter int unsigned FRAC_W  = logmag_pkg::LM_FRAC_W,
  parameter int unsigned REF_ITR = logmag_pkg::LM_REF_ITR,
  localparam int unsigned MAG_W  = 2 * IN_W,
  localparam int unsigned EXP_W  = $clog2(MAG_W),
  localparam int unsigned OUT_W  = EXP_W + FRAC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic                   refine_i,
  input  logic signed [IN_W-1:0] re_i,
  input  logic signed [IN_W-1:0] im_i,
  output logic                   out_valid_o,
  output logic [OUT_W-1:0]       log_o,
  output logic                   zero_o
);
  logic              take, s1_vld, s1_ref;
  logic [MAG_W-1:0]  s1_mag;
  logic [EXP_W-1:0]  n_exp, r_exp;
  logic [MANT_W-1:0] n_mant;
  logic [FRAC_W-1:0] n_frac, r_frac;
  logic              n_zero, r_zero, r_busy, r_last, r_load;

  assign in_ready_o = !(s1_vld && s1_ref) && !r_busy;
  assign take       = in_valid_i && in_ready_o;
  assign r_load     = s1_vld && s1_ref;

  logmag_sqsum #(.IN_W(IN_W)) u_sqsum (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .ref_i(refine_i),
    .re_i(re_i), .im_i(im_i), .vld_o(s1_vld), .ref_o(s1_ref), .mag_o(s1_mag)
  );

  logmag_norm #(.MAG_W(MAG_W), .MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_norm (
    .mag_i(s1_mag), .exp_o(n_exp), .mant_o(n_mant), .frac_o(n_frac), .zero_o(n_zero)
  );

  logmag_refine #(.EXP_W(EXP_W), .MANT_W(MANT_W), .FRAC_W(FRAC_W), .REF_ITR(REF_ITR)) u_refine (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(r_load), .exp_i(n_exp), .mant_i(n_mant),
    .zero_i(n_zero), .busy_o(r_busy), .last_o(r_last), .exp_o(r_exp),
    .frac_o(r_frac), .zero_o(r_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      log_o       <= '0;
      zero_o      <= 1'b0;
    end else if (s1_vld && !s1_ref) begin
      out_valid_o <= 1'b1;
      zero_o      <= n_zero;
      log_o       <= n_zero ? '0 : {n_exp, n_frac};
    end else if (r_last) begin
      out_valid_o <= 1'b1;
      zero_o      <= r_zero;
      log_o       <= r_zero ? '0 : {r_exp, r_frac};
    end else begin
      out_valid_o <= 1'b0;
    end
  end

  a_r4_fast_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !refine_i) |-> ##2 out_valid_o);
  a_r7_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && refine_i) |=> !in_ready_o);
  a_r5_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && zero_o) |-> (log_o == '0));
endmodule

// File: tb/fft_logmag_test.sv
module fft_logmag_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, refine = 1'b0;
  logic signed [15:0] re = '0, im = '0;
  logic in_ready, out_valid, zero;
  logic [12:0] lg;
  int checks = 0, errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  fft_logmag uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .refine_i(refine), .re_i(re), .im_i(im), .out_valid_o(out_valid),
    .log_o(lg), .zero_o(zero)
  );

  // re, im, refine, expected log, expected zero
  localparam int NV = 13;
  localparam logic [46:0] VECS [0:NV-1] = '{
    {16'h0001, 16'h0000, 1'b0, 13'd0,    1'b0},
    {16'h0003, 16'h0004, 1'b0, 13'd1168, 1'b0},
    {16'hFFFD, 16'h0004, 1'b0, 13'd1168, 1'b0},
    {16'h0000, 16'hFFF0, 1'b0, 13'd2048, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 13'd7936, 1'b0},
    {16'h0064, 16'h0000, 1'b0, 13'd3384, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 13'd0,    1'b1},
    {16'h00FF, 16'h00FF, 1'b0, 13'd4348, 1'b0},
    {16'h0001, 16'h0002, 1'b0, 13'd576,  1'b0},
    {16'h0001, 16'h0002, 1'b1, 13'd594,  1'b0},
    {16'h0003, 16'hFFFC, 1'b1, 13'd1188, 1'b0},
    {16'h0001, 16'h0001, 1'b1, 13'd256,  1'b0},
    {16'h0000, 16'h0000, 1'b1, 13'd0,    1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] r, input logic [15:0] i, input logic rf);
    re = r; im = i; refine = rf; in_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // R2 R3 R5 R6 R8: vector table, one sample at a time
    for (int v = 0; v < NV; v++) begin
      logic [46:0] e;
      int k;
      e = VECS[v];
      drive(e[46:31], e[30:15], e[14]);
      k = 0;
      @(negedge clk);
      in_valid = 1'b0;
      k = 1;
      while (!out_valid && k < 40) begin
        @(negedge clk);
        k++;
      end
      chk(lg == e[13:1], e[14] ? "R6 refined log" : "R2 R3 R8 fast log",
          int'(lg), int'(e[13:1]));
      chk(zero == e[0], "R5 zero flag", int'(zero), int'(e[0]));
      chk(k == (e[14] ? 10 : 2), e[14] ? "R6 refine latency" : "R4 fast latency", k,
          e[14] ? 10 : 2);
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 single-cycle valid", int'(out_valid), 0);
    end

    // R9: three back-to-back fast samples
    drive(16'h0003, 16'h0004, 1'b0);
    @(negedge clk);
    drive(16'h0064, 16'h0000, 1'b0);
    @(negedge clk);
    chk(out_valid && lg == 13'd1168, "R9 stream first", int'(lg), 1168);
    drive(16'h0000, 16'hFFF0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && lg == 13'd3384, "R9 stream second", int'(lg), 3384);
    @(negedge clk);
    chk(out_valid && lg == 13'd2048, "R9 stream third", int'(lg), 2048);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 stream ends", int'(out_valid), 0);

    // R7: ready low during refinement, offered input ignored
    drive(16'h0001, 16'h0002, 1'b1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready low while refining", int'(in_ready), 0);
    drive(16'h0064, 16'h0000, 1'b0);
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready still low", int'(in_ready), 0);
    in_valid = 1'b0;
    begin
      int k;
      k = 5;
      while (!out_valid && k < 40) begin
        @(negedge clk);
        k++;
      end
      chk(lg == 13'd594 && k == 10, "R7 refined result intact", int'(lg), 594);
    end
    chk(in_ready == 1'b1, "R7 ready back", int'(in_ready), 1);
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 ignored input no output", int'(out_valid), 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule